// File: doc/BRIEF.md
# Configurable Threshold Logic Element with Hysteresis

This block is one programmable cell of a fabric for NULL Convention Logic. Rather than building a fixed threshold gate, a static configuration word chooses a threshold and an integer weight for each of four single-wire inputs. With thresholds up to 5 and weights up to 3, the cell can form every fundamental hysteresis threshold gate, including the weighted ones. Mode bits add three options: a defined reset value, an inverted output, and an embedded register stage that is gated by a request/acknowledge line.

The cell is evaluated on a sampling clock. At each rising edge it updates one stored bit. The bit sets when the weighted sum of the asserted, used inputs reaches the threshold. It clears only when every used input has gone back to 0, which gives the output its hysteresis. When the register mode is on, the fourth input slot no longer counts as data and acts as the handshake line instead. Transitions toward DATA are then held back until that line asks for DATA, and transitions toward NULL are held back until it asks for NULL. The output is the stored bit, inverted when the inversion mode is set.

Top module: `ncl_logic_element`

## Requirements
- R1: The stored bit sets at a rising edge when it is 0 and the sum of the weights of the used inputs that are 1 is at least the threshold `cfg_thresh`. The weights sit in `cfg_weight`: input `din[0]` in bits [1:0], `din[1]` in bits [3:2], `din[2]` in bits [5:4] and `din[3]` in bits [7:6].
- R2: An input whose weight is 0 is unused. It takes no part in the set decision or in the hold decision.
- R3: Once the stored bit is 1, it stays 1 until a rising edge at which every used input is 0. At that edge it clears, subject to R9.
- R4: A threshold of 0 behaves as a threshold of 1, so setting still needs at least one used input at 1.
- R5: While `rst_n` is 0 at a rising edge, the stored bit is loaded with `cfg_rst_val` if `cfg_rst_en` is 1, and with 0 otherwise. This applies whatever the inputs are, and reset overrides every other rule.
- R6: `z` equals the stored bit when `cfg_inv` is 0 and its complement when `cfg_inv` is 1. The reset value always refers to the stored bit.
- R7: With `cfg_reg_en` at 1, `din[3]` is the handshake line (1 = request for DATA, 0 = request for NULL). Its weight is then ignored, so at most three inputs are used.
- R8: With `cfg_reg_en` at 1, the stored bit can set only at an edge where `din[3]` is 1.
- R9: With `cfg_reg_en` at 1, the stored bit can clear only at an edge where `din[3]` is 0.
- R10: The stored bit follows the inputs sampled at a rising edge. `z` shows the new value right after that edge, with no further register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_thresh | input | 3 | Threshold, 0 to 7 (0 acts as 1) |
| cfg_weight | input | 8 | Four 2-bit input weights, `din[0]` in the low bits |
| cfg_rst_en | input | 1 | Reset loads `cfg_rst_val` instead of 0 |
| cfg_rst_val | input | 1 | Reset value of the stored bit |
| cfg_inv | input | 1 | Invert the output |
| cfg_reg_en | input | 1 | Register mode; `din[3]` becomes the handshake line |
| din | input | 4 | Data inputs, single wire each |
| z | output | 1 | Gate output |

## Verification
Two functions can act in the same cycle. The first case is reset together with a set condition or a clear condition. The bench provokes it by pulling `rst_n` low at random, while random inputs are applied, under configurations whose reset value is 1 and others whose reset value is 0. The reset value must always win, and this is judged against a behavioural model that is compared every clock. The second case is a set or clear condition arriving while the handshake line points the wrong way. The bench drives random handshake values against a low threshold, so that such blocked transitions happen often. The model must show the stored bit held until the handshake line turns.

// File: rtl/ncl_le_pkg.sv
// Package: shared sizes and state encoding for the configurable threshold cell.
// Assumes the configuration is static while the cell is in use.
package ncl_le_pkg;
    localparam int unsigned LE_INPUTS   = 4;
    localparam int unsigned LE_W_BITS   = 2;
    localparam int unsigned LE_THR_BITS = 3;

    typedef enum logic {
        HS_NULL = 1'b0,
        HS_DATA = 1'b1
    } hyst_state_e;
endpackage

// File: rtl/ncl_use_mask.sv
// Module: decides which input slots take part in the threshold function.
// A slot is used when its weight is non-zero, except for the handshake slot
// (the highest one) while register mode is on. Purely combinational.
module ncl_use_mask #(
    parameter int unsigned N_IN   = 4,
    parameter int unsigned W_BITS = 2
) (
    input  logic [N_IN*W_BITS-1:0] weights,
    input  logic                   reg_en,
    output logic [N_IN-1:0]        used
);
    localparam int unsigned KI_SLOT = N_IN - 1;

    for (genvar g = 0; g < N_IN; g++) begin : g_slot
        if (g == KI_SLOT) begin : g_ki
            // purpose: handshake slot is excluded in register mode
            always_comb used[g] = (weights[g*W_BITS +: W_BITS] != '0) && !reg_en;
        end else begin : g_data
            // purpose: ordinary slot is used whenever it carries weight
            always_comb used[g] = (weights[g*W_BITS +: W_BITS] != '0);
        end
    end
endmodule

// File: rtl/ncl_weight_sum.sv
// Module: weighted sum of the asserted, used inputs, plus an any-high flag
// for the hold decision. Assumes SUM_W holds N_IN times the largest weight.
module ncl_weight_sum #(
    parameter int unsigned N_IN   = 4,
    parameter int unsigned W_BITS = 2,
    parameter int unsigned SUM_W  = 4
) (
    input  logic [N_IN-1:0]        din,
    input  logic [N_IN*W_BITS-1:0] weights,
    input  logic [N_IN-1:0]        used,
    output logic [SUM_W-1:0]       sum,
    output logic                   any_high
);
    logic [SUM_W-1:0] contrib [N_IN];
    logic [N_IN-1:0]  live;

    for (genvar g = 0; g < N_IN; g++) begin : g_term
        // purpose: one slot's weight when it is used and asserted
        always_comb begin
            live[g]    = din[g] && used[g];
            contrib[g] = live[g] ? SUM_W'(weights[g*W_BITS +: W_BITS]) : '0;
        end
    end

    // purpose: accumulate slot contributions and flag any live input
    always_comb begin
        sum = '0;
        for (int i = 0; i < int'(N_IN); i++) begin
            sum = sum + contrib[i];
        end
        any_high = |live;
    end
endmodule

// File: rtl/ncl_hyst_state.sv
// Module: the single stored bit with hysteresis, reset value and handshake
// gating. Sets on set_cond and clears once nothing used is high; in register
// mode ki gates both directions. Synchronous active-low reset wins.
module ncl_hyst_state
    import ncl_le_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_cond,
    input  logic any_high,
    input  logic reg_en,
    input  logic ki,
    input  logic rst_en,
    input  logic rst_val,
    output logic state
);
    hyst_state_e st_q, st_d;

    // purpose: next-state rule for the threshold hysteresis
    always_comb begin
        st_d = st_q;
        if (st_q == HS_NULL) begin
            if (set_cond && (!reg_en || ki)) st_d = HS_DATA;
        end else begin
            if (!any_high && (!reg_en || !ki)) st_d = HS_NULL;
        end
    end

    // purpose: state register with configurable synchronous reset value
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= (rst_en && rst_val) ? HS_DATA : HS_NULL;
        else        st_q <= st_d;
    end

    assign state = (st_q == HS_DATA);

    logic past_valid = 1'b0;
    // purpose: marks that $past now refers to a real sampled cycle
    always_ff @(posedge clk) past_valid <= 1'b1;

    a_r5_reset_value: assert property (@(posedge clk) disable iff (!past_valid)
        !$past(rst_n) |-> state == $past(rst_en && rst_val));

    a_r1_rise_needs_set: assert property (@(posedge clk) disable iff (!rst_n || !past_valid)
        ($past(rst_n) && $rose(state)) |-> $past(set_cond));

    a_r3_fall_needs_quiet: assert property (@(posedge clk) disable iff (!rst_n || !past_valid)
        ($past(rst_n) && $fell(state)) |-> !$past(any_high));

    a_r8_rise_needs_ki: assert property (@(posedge clk) disable iff (!rst_n || !past_valid)
        ($past(rst_n) && $past(reg_en) && $rose(state)) |-> $past(ki));

    a_r9_fall_needs_no_ki: assert property (@(posedge clk) disable iff (!rst_n || !past_valid)
        ($past(rst_n) && $past(reg_en) && $fell(state)) |-> !$past(ki));
endmodule

// File: rtl/ncl_logic_element.sv
// Module: top of the configurable threshold cell. Builds the used-slot mask,
// the weighted sum, the threshold compare (0 acts as 1), the hysteresis
// state and the optional output inversion. Configuration is assumed static.
module ncl_logic_element
    import ncl_le_pkg::*;
#(
    parameter int unsigned N_IN     = LE_INPUTS,
    parameter int unsigned W_BITS   = LE_W_BITS,
    parameter int unsigned THR_BITS = LE_THR_BITS
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [THR_BITS-1:0]    cfg_thresh,
    input  logic [N_IN*W_BITS-1:0] cfg_weight,
    input  logic                   cfg_rst_en,
    input  logic                   cfg_rst_val,
    input  logic                   cfg_inv,
    input  logic                   cfg_reg_en,
    input  logic [N_IN-1:0]        din,
    output logic                   z
);
    localparam int unsigned MAX_SUM = N_IN * ((1 << W_BITS) - 1);
    localparam int unsigned SUM_W   = $clog2(MAX_SUM + 1);
    localparam int unsigned KI_SLOT = N_IN - 1;

    logic [N_IN-1:0]     used;
    logic [SUM_W-1:0]    sum;
    logic                any_high;
    logic [THR_BITS-1:0] thr_eff;
    logic                set_cond;
    logic                state;

    ncl_use_mask #(.N_IN(N_IN), .W_BITS(W_BITS)) u_mask (
        .weights (cfg_weight),
        .reg_en  (cfg_reg_en),
        .used    (used)
    );

    ncl_weight_sum #(.N_IN(N_IN), .W_BITS(W_BITS), .SUM_W(SUM_W)) u_sum (
        .din      (din),
        .weights  (cfg_weight),
        .used     (used),
        .sum      (sum),
        .any_high (any_high)
    );

    // purpose: threshold compare, a zero threshold treated as one
    always_comb begin
        thr_eff  = (cfg_thresh == '0) ? THR_BITS'(1) : cfg_thresh;
        set_cond = int'(sum) >= int'(thr_eff);
    end

    ncl_hyst_state u_state (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_cond (set_cond),
        .any_high (any_high),
        .reg_en   (cfg_reg_en),
        .ki       (din[KI_SLOT]),
        .rst_en   (cfg_rst_en),
        .rst_val  (cfg_rst_val),
        .state    (state)
    );

    // purpose: optional inversion applied after the stored state
    always_comb z = state ^ cfg_inv;
endmodule

// File: tb/ncl_logic_element_bench.sv
// Bench: behavioural reference model compared with z on every clock.
module ncl_logic_element_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] cfg_thresh = 3'd1;
    logic [7:0] cfg_weight = 8'h55;
    logic       cfg_rst_en = 1'b0;
    logic       cfg_rst_val = 1'b0;
    logic       cfg_inv = 1'b0;
    logic       cfg_reg_en = 1'b0;
    logic [3:0] din = 4'h0;
    logic       z;

    int    n_checks = 0;
    int    n_fail   = 0;
    int    cyc      = 0;
    int    model_st = 0;
    bit    armed    = 1'b0;
    string tag      = "R5";

    always #4 clk = ~clk;

    ncl_logic_element u_ncl_logic_element (
        .clk(clk), .rst_n(rst_n), .cfg_thresh(cfg_thresh), .cfg_weight(cfg_weight),
        .cfg_rst_en(cfg_rst_en), .cfg_rst_val(cfg_rst_val), .cfg_inv(cfg_inv),
        .cfg_reg_en(cfg_reg_en), .din(din), .z(z)
    );

    // reference model: integer weights, evaluated at each rising edge
    always @(posedge clk) begin
        int sum, thr, w;
        bit anyh, ki;
        cyc++;
        sum = 0; anyh = 0;
        for (int i = 0; i < 4; i++) begin
            if (cfg_reg_en && i == 3) continue;
            w = (int'(cfg_weight) >> (2 * i)) & 3;
            if (w != 0 && din[i]) begin
                sum += w;
                anyh = 1;
            end
        end
        thr = (cfg_thresh == 0) ? 1 : int'(cfg_thresh);
        ki  = din[3];
        if (!rst_n) model_st = (cfg_rst_en && cfg_rst_val) ? 1 : 0;
        else if (model_st == 0) begin
            if (sum >= thr && (!cfg_reg_en || ki)) model_st = 1;
        end else if (!anyh && (!cfg_reg_en || !ki)) model_st = 0;
        armed = 1'b1;
        if (cyc > 100000) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    task automatic compare();
        bit exp_z;
        exp_z = (model_st[0]) ^ cfg_inv;
        n_checks++;
        if (z !== exp_z) begin
            n_fail++;
            $display("FAIL %s cycle %0d: z=%b expected %b", tag, cyc, z, exp_z);
        end
    endtask

    // mode 0: uniform inputs, 1: sparse inputs, 2: uniform with random resets
    task automatic run_phase(input string t, input logic [2:0] m, input logic [7:0] w,
                             input bit ren, input bit rval, input bit inv, input bit reg_mode,
                             input int n, input int mode);
        @(negedge clk);
        if (armed) compare();
        tag = t; rst_n = 1'b0; din = 4'h0;
        cfg_thresh = m; cfg_weight = w; cfg_rst_en = ren; cfg_rst_val = rval;
        cfg_inv = inv; cfg_reg_en = reg_mode;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            compare();
            rst_n = (mode == 2) ? (($urandom % 8) != 0) : 1'b1;
            if (mode == 1) din = 4'($urandom & $urandom & $urandom);
            else           din = 4'($urandom);
        end
    endtask

    initial begin
        repeat (2) @(negedge clk);
        compare(); // R5 reset state
        run_phase("R5",  3'd2, 8'b01_01_01_01, 1, 1, 0, 0, 400, 2);
        run_phase("R5",  3'd3, 8'b01_01_01_01, 1, 0, 0, 0, 300, 2);
        run_phase("R1",  3'd3, 8'b01_01_01_10, 0, 0, 0, 0, 400, 1);
        run_phase("R1",  3'd5, 8'b00_10_10_11, 0, 0, 0, 0, 400, 0);
        run_phase("R2",  3'd2, 8'b01_01_00_01, 0, 0, 0, 0, 400, 1);
        run_phase("R3",  3'd4, 8'b01_01_01_01, 0, 0, 0, 0, 400, 1);
        run_phase("R4",  3'd0, 8'b00_00_01_01, 0, 0, 0, 0, 300, 1);
        run_phase("R6",  3'd2, 8'b01_01_01_01, 1, 0, 1, 0, 300, 2);
        run_phase("R6",  3'd1, 8'b01_01_01_01, 1, 1, 1, 0, 300, 2);
        run_phase("R7",  3'd2, 8'b11_01_01_01, 0, 0, 0, 1, 400, 0);
        run_phase("R8",  3'd1, 8'b11_00_00_01, 0, 0, 0, 1, 400, 0);
        run_phase("R9",  3'd1, 8'b00_00_01_01, 1, 1, 1, 1, 400, 1);
        run_phase("R10", 3'd1, 8'b01_01_01_01, 0, 0, 0, 0, 300, 0);
        @(negedge clk);
        compare();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule